// File: doc/BRIEF.md
# Windowed Memory Address Mapper

This block turns the addresses a small processor core issues into physical targets. It handles two kinds of address. A 16-bit data address goes either straight to internal data RAM or through a 16 KB window. A word-granular instruction PC is turned into a byte address and sent either to instruction memory or to one segment of a segmented unified memory. Three 16-bit map registers steer the redirection: one data map and two instruction maps. Each map has a flag bit that picks instruction memory or a unified-memory segment.

The translation is purely combinational. The map registers are written through a simple write port and take fixed values on reset. A per-segment presence mask comes in from outside, so the block can flag an access that goes to a unified segment with no backing store. The outputs are a target code, a physical byte offset, a segment number and fault or warning flags. They feed the memory controllers that sit beside this block.

Top module: `win_addr_xlate`

## Requirements
- R1: A data address in 0x0000..0x7FFF selects data RAM (target code 0), with the offset equal to the address and segment 0.
- R2: A data address in 0xC000..0xFFFF selects data RAM at the same offset. The I/O warning is raised for every such address except 0xFF00..0xFF0F, and it is never raised below 0xC000.
- R3: A data address in 0x8000..0xBFFF with data-map bit 12 set selects instruction memory (target code 1), at offset (data-map bits 3:0) × 0x4000 + (address − 0x8000).
- R4: A data address in 0x8000..0xBFFF with data-map bit 12 clear selects unified memory (target code 2). The segment is data-map bits 9:3, and the offset within the segment is (data-map bits 2:0) × 0x4000 + (address − 0x8000).
- R5: A data window access to a unified segment whose presence bit is 0 raises the data map fault. No other data access raises it.
- R6: The fetch byte address is PC × 4. When bit 17 of that byte address is 1, instruction map 1 governs the fetch; otherwise instruction map 0 governs it.
- R7: When the governing instruction map has bit 12 set, the fetch goes to instruction memory (code 1) at offset PC × 4 with segment 0. Otherwise it goes to unified memory (code 2), with the segment equal to map bits 7:0 and the offset equal to PC × 4.
- R8: A fetch from a unified segment whose presence bit is 0 raises the illegal-fetch fault. A fetch from a present segment, or from instruction memory, does not.
- R9: Reset loads 0x1000 into both instruction maps and 0 into the data map.
- R10: A map write with select 0 loads the data map, select 1 loads instruction map 0 and select 2 loads instruction map 1, each taking effect from the next clock. Select 3 changes no map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_wr_en | input | 1 | Map register write strobe |
| map_wr_sel | input | 2 | Map select: 0 data, 1 instr map 0, 2 instr map 1, 3 none |
| map_wr_data | input | 16 | Value written to the selected map |
| seg_present | input | 256 | One bit per unified segment; 1 = backed |
| d_addr | input | 16 | Data address |
| d_tgt | output | 2 | Data target: 0 data RAM, 1 instr memory, 2 unified |
| d_offset | output | 18 | Physical byte offset of the data access |
| d_seg | output | 8 | Unified segment of the data access |
| d_io_warn | output | 1 | Data address is in I/O space outside the 16-byte quiet block |
| d_map_fault | output | 1 | Data window hits an absent segment |
| pc | input | 16 | Word-granular instruction PC |
| f_tgt | output | 2 | Fetch target: 1 instr memory, 2 unified |
| f_offset | output | 18 | Physical byte offset of the fetch |
| f_seg | output | 8 | Unified segment of the fetch |
| f_ill_fault | output | 1 | Fetch hits an absent segment |

## Verification
The data path is driven through a table of address and data-map pairs. The table covers each region edge (0x7FFF/0x8000, 0xBFFF/0xC000, 0xFF00, 0xFF0F, 0xFF10). It uses windows with the flag set and clear, and segment and base fields at their extremes, so that swapped bit fields or a missing window offset give a wrong offset or segment. Window accesses to a present segment and to an absent one separate a correct fault from one that is stuck or inverted. Fetches use PCs on both sides of the bit-17 split, with the two instruction maps programmed differently, so a wrong map choice shows up. Reset values are checked from the port side, and so is a write with the unused select code.

// File: rtl/wxl_pkg.sv
package wxl_pkg;
    localparam int MAP_W = 16;

    typedef enum logic [1:0] {
        TGT_DRAM = 2'd0,
        TGT_IMEM = 2'd1,
        TGT_UMEM = 2'd2
    } tgt_e;

    typedef enum logic [1:0] {
        SEL_DMAP  = 2'd0,
        SEL_IMAP0 = 2'd1,
        SEL_IMAP1 = 2'd2,
        SEL_NONE  = 2'd3
    } msel_e;

    typedef struct packed {
        logic [MAP_W-1:0] dmap;
        logic [MAP_W-1:0] imap0;
        logic [MAP_W-1:0] imap1;
    } maps_t;

    localparam logic [MAP_W-1:0] IMAP_RST = 16'h1000;
    localparam logic [MAP_W-1:0] DMAP_RST = 16'h0000;
    localparam int               FLAG_BIT = 12;
endpackage

// File: rtl/wxl_map_regs.sv
module wxl_map_regs
    import wxl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [MAP_W-1:0] wr_data,
    output maps_t            maps
);
    maps_t maps_d, maps_q;

    always_comb begin
        maps_d = maps_q;
        if (wr_en) begin
            case (msel_e'(wr_sel))
                SEL_DMAP:  maps_d.dmap  = wr_data;
                SEL_IMAP0: maps_d.imap0 = wr_data;
                SEL_IMAP1: maps_d.imap1 = wr_data;
                default:   maps_d       = maps_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            maps_q.dmap  <= DMAP_RST;
            maps_q.imap0 <= IMAP_RST;
            maps_q.imap1 <= IMAP_RST;
        end else begin
            maps_q <= maps_d;
        end
    end

    assign maps = maps_q;

    assert_dmap_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0) |=> (maps.dmap == $past(wr_data)));
    assert_imap1_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd2) |=> (maps.imap1 == $past(wr_data)));
    assert_bad_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3) |=> $stable(maps));
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(maps));
endmodule

// File: rtl/wxl_data_xlate.sv
module wxl_data_xlate
    import wxl_pkg::*;
#(
    parameter int SEG_W = 8,
    parameter int OFF_W = 18
) (
    input  logic [15:0]         addr,
    input  logic [MAP_W-1:0]    dmap,
    input  logic [2**SEG_W-1:0] present,
    output logic [1:0]          tgt,
    output logic [OFF_W-1:0]    off,
    output logic [SEG_W-1:0]    seg,
    output logic                io_warn,
    output logic                map_fault
);
    localparam int WIN_W = 14;

    logic in_window, in_io, quiet;

    always_comb begin
        in_window = (addr[15:14] == 2'b10);
        in_io     = (addr[15:14] == 2'b11);
        quiet     = (addr[15:4] == 12'hFF0);
        tgt       = TGT_DRAM;
        off       = OFF_W'(addr);
        seg       = '0;
        io_warn   = in_io && !quiet;
        map_fault = 1'b0;
        if (in_window) begin
            if (dmap[FLAG_BIT]) begin
                tgt = TGT_IMEM;
                off = OFF_W'({dmap[3:0], addr[WIN_W-1:0]});
            end else begin
                tgt       = TGT_UMEM;
                seg       = SEG_W'(dmap[9:3]);
                off       = OFF_W'({dmap[2:0], addr[WIN_W-1:0]});
                map_fault = !present[SEG_W'(dmap[9:3])];
            end
        end
    end
endmodule

// File: rtl/wxl_fetch_xlate.sv
module wxl_fetch_xlate
    import wxl_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int SEG_W = 8,
    parameter int OFF_W = PC_W + 2
) (
    input  logic [PC_W-1:0]     pc,
    input  logic [MAP_W-1:0]    imap0,
    input  logic [MAP_W-1:0]    imap1,
    input  logic [2**SEG_W-1:0] present,
    output logic [1:0]          tgt,
    output logic [OFF_W-1:0]    off,
    output logic [SEG_W-1:0]    seg,
    output logic                ill_fault
);
    localparam int SPLIT_BIT = 17;

    logic [OFF_W-1:0] byte_addr;
    logic [MAP_W-1:0] imap;

    always_comb begin
        byte_addr = OFF_W'({pc, 2'b00});
        imap      = byte_addr[SPLIT_BIT] ? imap1 : imap0;
        off       = byte_addr;
        if (imap[FLAG_BIT]) begin
            tgt       = TGT_IMEM;
            seg       = '0;
            ill_fault = 1'b0;
        end else begin
            tgt       = TGT_UMEM;
            seg       = imap[SEG_W-1:0];
            ill_fault = !present[imap[SEG_W-1:0]];
        end
    end
endmodule

// File: rtl/win_addr_xlate.sv
module win_addr_xlate
    import wxl_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int SEG_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                map_wr_en,
    input  logic [1:0]          map_wr_sel,
    input  logic [15:0]         map_wr_data,
    input  logic [2**SEG_W-1:0] seg_present,
    input  logic [15:0]         d_addr,
    output logic [1:0]          d_tgt,
    output logic [PC_W+1:0]     d_offset,
    output logic [SEG_W-1:0]    d_seg,
    output logic                d_io_warn,
    output logic                d_map_fault,
    input  logic [PC_W-1:0]     pc,
    output logic [1:0]          f_tgt,
    output logic [PC_W+1:0]     f_offset,
    output logic [SEG_W-1:0]    f_seg,
    output logic                f_ill_fault
);
    localparam int OFF_W = PC_W + 2;

    maps_t maps;

    wxl_map_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (map_wr_en),
        .wr_sel  (map_wr_sel),
        .wr_data (map_wr_data),
        .maps    (maps)
    );

    wxl_data_xlate #(.SEG_W(SEG_W), .OFF_W(OFF_W)) u_data (
        .addr      (d_addr),
        .dmap      (maps.dmap),
        .present   (seg_present),
        .tgt       (d_tgt),
        .off       (d_offset),
        .seg       (d_seg),
        .io_warn   (d_io_warn),
        .map_fault (d_map_fault)
    );

    wxl_fetch_xlate #(.PC_W(PC_W), .SEG_W(SEG_W), .OFF_W(OFF_W)) u_fetch (
        .pc        (pc),
        .imap0     (maps.imap0),
        .imap1     (maps.imap1),
        .present   (seg_present),
        .tgt       (f_tgt),
        .off       (f_offset),
        .seg       (f_seg),
        .ill_fault (f_ill_fault)
    );

    assert_low_direct_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !d_addr[15] |-> (d_tgt == 2'd0 && d_offset == OFF_W'(d_addr) && !d_io_warn));
    assert_io_warn_R2: assert property (@(posedge clk) disable iff (!rst_n)
        d_io_warn |-> (d_addr >= 16'hC000 && d_addr[15:4] != 12'hFF0 && d_tgt == 2'd0));
    assert_win_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        d_map_fault |-> (d_tgt == 2'd2 && !seg_present[d_seg]));
    assert_fetch_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (f_offset == OFF_W'({pc, 2'b00})) && (f_tgt != 2'd0));
    assert_ill_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        f_ill_fault |-> (f_tgt == 2'd2 && !seg_present[f_seg]));
endmodule

// File: tb/sim_win_addr_xlate.sv
module sim_win_addr_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_wr_en = 1'b0;
    logic [1:0]  map_wr_sel = 2'd0;
    logic [15:0] map_wr_data = 16'h0;
    logic [255:0] seg_present;
    logic [15:0] d_addr = 16'h0;
    logic [1:0]  d_tgt;
    logic [17:0] d_offset;
    logic [7:0]  d_seg;
    logic        d_io_warn, d_map_fault;
    logic [15:0] pc = 16'h0;
    logic [1:0]  f_tgt;
    logic [17:0] f_offset;
    logic [7:0]  f_seg;
    logic        f_ill_fault;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    win_addr_xlate u0 (
        .clk(clk), .rst_n(rst_n), .map_wr_en(map_wr_en), .map_wr_sel(map_wr_sel),
        .map_wr_data(map_wr_data), .seg_present(seg_present), .d_addr(d_addr),
        .d_tgt(d_tgt), .d_offset(d_offset), .d_seg(d_seg), .d_io_warn(d_io_warn),
        .d_map_fault(d_map_fault), .pc(pc), .f_tgt(f_tgt), .f_offset(f_offset),
        .f_seg(f_seg), .f_ill_fault(f_ill_fault)
    );

    typedef struct packed {
        logic [15:0] dmap;
        logic [15:0] addr;
        logic [1:0]  tgt;
        logic [17:0] off;
        logic [7:0]  seg;
        logic        warn;
        logic        fault;
    } dvec_t;

    localparam int NV = 14;
    localparam dvec_t DV [NV] = '{
        '{16'h0000, 16'h1234, 2'd0, 18'h01234, 8'd0,   1'b0, 1'b0},  // R1
        '{16'h1005, 16'h7FFF, 2'd0, 18'h07FFF, 8'd0,   1'b0, 1'b0},  // R1
        '{16'h0000, 16'h8000, 2'd2, 18'h00000, 8'd0,   1'b0, 1'b0},  // R4
        '{16'h1003, 16'h8010, 2'd1, 18'h0C010, 8'd0,   1'b0, 1'b0},  // R3
        '{16'h100F, 16'hBFFF, 2'd1, 18'h3FFFF, 8'd0,   1'b0, 1'b0},  // R3
        '{16'hF018, 16'h8001, 2'd1, 18'h20001, 8'd0,   1'b0, 1'b0},  // R3
        '{16'h000D, 16'h9000, 2'd2, 18'h15000, 8'd1,   1'b0, 1'b0},  // R4
        '{16'h03FF, 16'hA000, 2'd2, 18'h1E000, 8'd127, 1'b0, 1'b0},  // R4
        '{16'h0018, 16'h8004, 2'd2, 18'h00004, 8'd3,   1'b0, 1'b1},  // R5
        '{16'h0018, 16'hC000, 2'd0, 18'h0C000, 8'd0,   1'b1, 1'b0},  // R2
        '{16'h0018, 16'hFF00, 2'd0, 18'h0FF00, 8'd0,   1'b0, 1'b0},  // R2
        '{16'h0018, 16'hFF0F, 2'd0, 18'h0FF0F, 8'd0,   1'b0, 1'b0},  // R2
        '{16'h0018, 16'hFF10, 2'd0, 18'h0FF10, 8'd0,   1'b1, 1'b0},  // R2
        '{16'h0018, 16'hFFFF, 2'd0, 18'h0FFFF, 8'd0,   1'b1, 1'b0}   // R2
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_map(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        map_wr_en = 1'b1; map_wr_sel = sel; map_wr_data = val;
        @(negedge clk);
        map_wr_en = 1'b0;
    endtask

    task automatic chk_fetch(input string req, input logic [15:0] p, input logic [1:0] t,
                             input logic [17:0] o, input logic [7:0] s, input logic flt);
        pc = p;
        #1;
        chk({req, " f_tgt"}, 32'(f_tgt), 32'(t));
        chk({req, " f_offset"}, 32'(f_offset), 32'(o));
        chk({req, " f_seg"}, 32'(f_seg), 32'(s));
        chk({req, " f_ill_fault"}, 32'(f_ill_fault), 32'(flt));
    endtask

    initial begin
        seg_present = '0;
        seg_present[0] = 1'b1; seg_present[1] = 1'b1;
        seg_present[2] = 1'b1; seg_present[127] = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state seen at the ports
        d_addr = 16'h8000;
        #1;
        chk("R9 dmap reset tgt", 32'(d_tgt), 32'd2);
        chk("R9 dmap reset seg", 32'(d_seg), 32'd0);
        chk("R9 dmap reset off", 32'(d_offset), 32'd0);
        chk_fetch("R9 imap0 reset", 16'h0005, 2'd1, 18'h00014, 8'd0, 1'b0);
        chk_fetch("R9 imap1 reset", 16'h8000, 2'd1, 18'h20000, 8'd0, 1'b0);

        // data table
        for (int i = 0; i < NV; i++) begin
            wr_map(2'd0, DV[i].dmap);
            d_addr = DV[i].addr;
            #1;
            chk($sformatf("R1-R5 vec%0d tgt", i), 32'(d_tgt), 32'(DV[i].tgt));
            chk($sformatf("R1-R5 vec%0d off", i), 32'(d_offset), 32'(DV[i].off));
            chk($sformatf("R1-R5 vec%0d seg", i), 32'(d_seg), 32'(DV[i].seg));
            chk($sformatf("R2 vec%0d warn", i), 32'(d_io_warn), 32'(DV[i].warn));
            chk($sformatf("R5 vec%0d fault", i), 32'(d_map_fault), 32'(DV[i].fault));
        end

        // R6 / R7: imap0 to present unified segment 2, imap1 untouched
        wr_map(2'd1, 16'h0002);
        chk_fetch("R7 unified fetch", 16'h0010, 2'd2, 18'h00040, 8'd2, 1'b0);
        chk_fetch("R6 upper half imap1", 16'h8001, 2'd1, 18'h20004, 8'd0, 1'b0);
        chk_fetch("R6 last low word", 16'h7FFF, 2'd2, 18'h1FFFC, 8'd2, 1'b0);

        // R8: imap1 to absent segment 0x50
        wr_map(2'd2, 16'h0050);
        chk_fetch("R8 absent seg", 16'h8001, 2'd2, 18'h20004, 8'h50, 1'b1);
        chk_fetch("R8 low half clean", 16'h0001, 2'd2, 18'h00004, 8'd2, 1'b0);
        wr_map(2'd2, 16'h007F);
        chk_fetch("R8 present seg", 16'hFFFF, 2'd2, 18'h3FFFC, 8'h7F, 1'b0);

        // R10: unused select changes nothing
        wr_map(2'd3, 16'h1000);
        chk_fetch("R10 sel3 imap1", 16'h8001, 2'd2, 18'h20004, 8'h7F, 1'b0);
        chk_fetch("R10 sel3 imap0", 16'h0001, 2'd2, 18'h00004, 8'd2, 1'b0);
        d_addr = 16'h8004;
        #1;
        chk("R10 sel3 dmap seg", 32'(d_seg), 32'd3);
        chk("R10 sel3 dmap fault", 32'(d_map_fault), 32'd1);

        // R9: second reset restores defaults
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_fetch("R9 rereset imap1", 16'h8001, 2'd1, 18'h20004, 8'd0, 1'b0);
        chk_fetch("R9 rereset imap0", 16'h0001, 2'd1, 18'h00004, 8'd0, 1'b0);
        d_addr = 16'h8004;
        #1;
        chk("R9 rereset dmap seg", 32'(d_seg), 32'd0);
        chk("R9 rereset dmap fault", 32'(d_map_fault), 32'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule